// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-facing register set of a four-channel DMA controller. Software reaches it over a narrow 8-bit I/O bus with a 16-location address window. Each channel owns a 16-bit start address and a 16-bit transfer count. Because the bus carries only one byte per access, both halves of a 16-bit value pass through the same location. A single shared byte-pointer flip-flop decides whether an access touches the low byte or the high byte, and every access toggles it. Software puts the pointer into a known state by writing to a dedicated clear location.

Besides the per-channel values, the block keeps a mask bit and a mode field for each channel, a command byte, a software request bit for each channel, and terminal-count flags that are reported through the status location. Mask, mode and request writes name their target channel inside the data byte, not in the address. The transfer engine sits outside the block. It reads the programmed values from output ports, writes back its working address and count, and pulses terminal-count events. Bus reads of an address or count location return the working value that the engine last wrote back.

Top module: `dma_prog_regs`

## Requirements
- R1: After reset, all four mask bits are 1, the command byte and the request bits are 0, every address, count and mode field is 0, and the byte pointer selects the low byte.
- R2: A bus write to offset 2n writes channel n's address, the low byte when the pointer is clear and the high byte when it is set. The write updates both the base copy and the working copy, and then toggles the pointer.
- R3: A bus write to offset 2n+1 writes channel n's count in the same two-step way. The count is stored exactly as written, which is one less than the number of transfers.
- R4: A bus read of offset 2n or 2n+1 returns a byte of the working address or working count, chosen by the pointer, and toggles the pointer. Reads and writes share one pointer.
- R5: Any write to offset 12 forces the pointer to the low-byte state, whatever the data.
- R6: A write to offset 10 picks a channel with data bits [1:0]. Data bit 2 set masks that channel and bit 2 clear unmasks it. The other channels keep their mask bits.
- R7: A write to offset 15 loads all four mask bits from data bits [3:0]. Bit n is channel n.
- R8: Any write to offset 14 clears all four mask bits.
- R9: A write to offset 11 picks a channel with data bits [1:0] and stores data bits [7:2] as that channel's 6-bit mode. For example, 0x45 gives channel 1 mode 0x11.
- R10: A write to offset 13 is a master clear. It resets the pointer to low, sets all mask bits, and clears the command byte, the request bits and the terminal-count flags. Address, count and mode values are kept.
- R11: A write to offset 8 stores the command byte. A read of offset 8 returns {request[3:0], tc[3:0]} and clears the tc flags. A tc pulse from the engine in the same cycle wins over the clear.
- R12: A write to offset 9 picks a channel with data bits [1:0] and sets its request bit if data bit 2 is 1, or clears it if bit 2 is 0.
- R13: An engine writeback updates only the working address and count of the channel it names. The base copies are unchanged. A bus write to the same channel in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset on the I/O bus |
| busWrData | input | 8 | Write data byte |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access (ignored while busWr is high) |
| busRdData | output | 8 | Read data, combinational from busAddr and the current state |
| engWrEn | input | 1 | Engine writeback strobe |
| engWrCh | input | 2 | Channel targeted by the writeback |
| engWrAddr | input | 16 | Working address written back |
| engWrCount | input | 16 | Working count written back |
| engTc | input | 4 | Terminal-count pulses, one bit per channel |
| chBaseAddr | output | 64 | Base addresses, channel n in bits [16n+15:16n] |
| chBaseCount | output | 64 | Base counts, same packing |
| chCurAddr | output | 64 | Working addresses, same packing |
| chCurCount | output | 64 | Working counts, same packing |
| chMask | output | 4 | Mask bits, bit n is channel n |
| chMode | output | 24 | Mode fields, channel n in bits [6n+5:6n] |
| cmdReg | output | 8 | Command byte |
| chReq | output | 4 | Software request bits |

## Verification
The byte sequencing is tested with writes followed by reads on the same location, so a swapped byte order or a pointer that fails to toggle shows up as a wrong byte. A clear-pointer write is placed between two writes so that an ignored clear overwrites the high byte instead of the low one. Reads are mixed with writes to show that the two share a single pointer. Engine writebacks followed by bus reads separate the working copy from the base copy. Mask, mode and request writes target several channels with both polarities of the data bit, and a master clear issued while the pointer points at the high byte shows that the pointer is reset along with the other state.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;
  localparam int NUM_CH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int BYTE_W  = 8;
  localparam int REG_W   = 2 * BYTE_W;
  localparam int MODE_W  = BYTE_W - CH_W;
  localparam int OFS_W   = 4;

  localparam logic [OFS_W-1:0] OFS_CMD_STAT = 4'd8;
  localparam logic [OFS_W-1:0] OFS_REQ      = 4'd9;
  localparam logic [OFS_W-1:0] OFS_MASK1    = 4'd10;
  localparam logic [OFS_W-1:0] OFS_MODE     = 4'd11;
  localparam logic [OFS_W-1:0] OFS_CLR_PTR  = 4'd12;
  localparam logic [OFS_W-1:0] OFS_MCLR     = 4'd13;
  localparam logic [OFS_W-1:0] OFS_CLR_MASK = 4'd14;
  localparam logic [OFS_W-1:0] OFS_MASK_ALL = 4'd15;

  // strobes from control to datapath
  typedef struct packed {
    logic            wrAddr;
    logic            wrCount;
    logic            wrCmd;
    logic            wrReq;
    logic            wrMask1;
    logic            wrMaskAll;
    logic            clrMask;
    logic            wrMode;
    logic            mclr;
    logic            rdStatus;
    logic            byteHi;
    logic [CH_W-1:0] ch;
  } dmaStrobes_t;
endpackage

// File: rtl/dma_prog_ctrl.sv
module dma_prog_ctrl
  import dma_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OFS_W-1:0] busAddr,
  input  logic             busWr,
  input  logic             busRd,
  output dmaStrobes_t      strb
);
  logic ptrHi;
  logic rdOnly;
  logic chanSpace;

  assign rdOnly    = busRd && !busWr;
  assign chanSpace = !busAddr[OFS_W-1];

  // shared byte pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrHi <= 1'b0;
    end else if (busWr && (busAddr == OFS_MCLR || busAddr == OFS_CLR_PTR)) begin
      ptrHi <= 1'b0;
    end else if ((busWr || rdOnly) && chanSpace) begin
      ptrHi <= !ptrHi;
    end
  end

  always_comb begin
    strb           = '0;
    strb.byteHi    = ptrHi;
    strb.ch        = busAddr[CH_W:1];
    strb.wrAddr    = busWr && chanSpace && !busAddr[0];
    strb.wrCount   = busWr && chanSpace &&  busAddr[0];
    strb.wrCmd     = busWr && busAddr == OFS_CMD_STAT;
    strb.wrReq     = busWr && busAddr == OFS_REQ;
    strb.wrMask1   = busWr && busAddr == OFS_MASK1;
    strb.wrMode    = busWr && busAddr == OFS_MODE;
    strb.mclr      = busWr && busAddr == OFS_MCLR;
    strb.clrMask   = busWr && busAddr == OFS_CLR_MASK;
    strb.wrMaskAll = busWr && busAddr == OFS_MASK_ALL;
    strb.rdStatus  = rdOnly && busAddr == OFS_CMD_STAT;
  end
endmodule

// File: rtl/dma_prog_chan.sv
module dma_prog_chan
  import dma_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrAddr,
  input  logic              busWrCount,
  input  logic              byteHi,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              engEn,
  input  logic [REG_W-1:0]  engAddr,
  input  logic [REG_W-1:0]  engCount,
  output logic [REG_W-1:0]  baseAddr,
  output logic [REG_W-1:0]  baseCount,
  output logic [REG_W-1:0]  curAddr,
  output logic [REG_W-1:0]  curCount
);
  function automatic logic [REG_W-1:0] putByte(input logic [REG_W-1:0] old,
                                               input logic hi,
                                               input logic [BYTE_W-1:0] d);
    putByte = hi ? {d, old[BYTE_W-1:0]} : {old[REG_W-1:BYTE_W], d};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      baseCount <= '0;
      curAddr   <= '0;
      curCount  <= '0;
    end else begin
      if (busWrAddr) begin
        baseAddr <= putByte(baseAddr, byteHi, wrData);
        curAddr  <= putByte(curAddr, byteHi, wrData);
      end else if (engEn) begin
        curAddr  <= engAddr;
      end
      if (busWrCount) begin
        baseCount <= putByte(baseCount, byteHi, wrData);
        curCount  <= putByte(curCount, byteHi, wrData);
      end else if (engEn) begin
        curCount  <= engCount;
      end
    end
  end
endmodule

// File: rtl/dma_prog_datapath.sv
module dma_prog_datapath
  import dma_prog_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dmaStrobes_t              strb,
  input  logic [OFS_W-1:0]         busAddr,
  input  logic [BYTE_W-1:0]        busWrData,
  output logic [BYTE_W-1:0]        busRdData,
  input  logic                     engWrEn,
  input  logic [CH_W-1:0]          engWrCh,
  input  logic [REG_W-1:0]         engWrAddr,
  input  logic [REG_W-1:0]         engWrCount,
  input  logic [NUM_CH-1:0]        engTc,
  output logic [NUM_CH*REG_W-1:0]  chBaseAddr,
  output logic [NUM_CH*REG_W-1:0]  chBaseCount,
  output logic [NUM_CH*REG_W-1:0]  chCurAddr,
  output logic [NUM_CH*REG_W-1:0]  chCurCount,
  output logic [NUM_CH-1:0]        chMask,
  output logic [NUM_CH*MODE_W-1:0] chMode,
  output logic [BYTE_W-1:0]        cmdReg,
  output logic [NUM_CH-1:0]        chReq
);
  logic [NUM_CH-1:0] tcFlag;
  logic [CH_W-1:0]   dataCh;

  assign dataCh = busWrData[CH_W-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic hitCh;
    assign hitCh = strb.ch == CH_W'(i);
    dma_prog_chan u_chan (
      .clk        (clk),
      .rstN       (rstN),
      .busWrAddr  (strb.wrAddr && hitCh),
      .busWrCount (strb.wrCount && hitCh),
      .byteHi     (strb.byteHi),
      .wrData     (busWrData),
      .engEn      (engWrEn && engWrCh == CH_W'(i)),
      .engAddr    (engWrAddr),
      .engCount   (engWrCount),
      .baseAddr   (chBaseAddr[i*REG_W +: REG_W]),
      .baseCount  (chBaseCount[i*REG_W +: REG_W]),
      .curAddr    (chCurAddr[i*REG_W +: REG_W]),
      .curCount   (chCurCount[i*REG_W +: REG_W])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chMode[i*MODE_W +: MODE_W] <= '0;
      end else if (strb.wrMode && dataCh == CH_W'(i)) begin
        chMode[i*MODE_W +: MODE_W] <= busWrData[BYTE_W-1:CH_W];
      end
    end
  end

  // mask bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chMask <= '1;
    end else if (strb.mclr) begin
      chMask <= '1;
    end else if (strb.clrMask) begin
      chMask <= '0;
    end else if (strb.wrMaskAll) begin
      chMask <= busWrData[NUM_CH-1:0];
    end else if (strb.wrMask1) begin
      chMask[dataCh] <= busWrData[CH_W];
    end
  end

  // command, request, terminal count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      chReq  <= '0;
      tcFlag <= '0;
    end else if (strb.mclr) begin
      cmdReg <= '0;
      chReq  <= '0;
      tcFlag <= '0;
    end else begin
      if (strb.wrCmd) cmdReg <= busWrData;
      if (strb.wrReq) chReq[dataCh] <= busWrData[CH_W];
      tcFlag <= (strb.rdStatus ? '0 : tcFlag) | engTc;
    end
  end

  // read mux
  always_comb begin
    logic [REG_W-1:0] sel;
    sel       = busAddr[0] ? chCurCount[strb.ch*REG_W +: REG_W]
                           : chCurAddr[strb.ch*REG_W +: REG_W];
    busRdData = '0;
    if (!busAddr[OFS_W-1]) begin
      busRdData = strb.byteHi ? sel[REG_W-1:BYTE_W] : sel[BYTE_W-1:0];
    end else if (busAddr == OFS_CMD_STAT) begin
      busRdData = {chReq, tcFlag};
    end
  end
endmodule

// File: rtl/dma_prog_regs.sv
module dma_prog_regs
  import dma_prog_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [OFS_W-1:0]         busAddr,
  input  logic [BYTE_W-1:0]        busWrData,
  input  logic                     busWr,
  input  logic                     busRd,
  output logic [BYTE_W-1:0]        busRdData,
  input  logic                     engWrEn,
  input  logic [CH_W-1:0]          engWrCh,
  input  logic [REG_W-1:0]         engWrAddr,
  input  logic [REG_W-1:0]         engWrCount,
  input  logic [NUM_CH-1:0]        engTc,
  output logic [NUM_CH*REG_W-1:0]  chBaseAddr,
  output logic [NUM_CH*REG_W-1:0]  chBaseCount,
  output logic [NUM_CH*REG_W-1:0]  chCurAddr,
  output logic [NUM_CH*REG_W-1:0]  chCurCount,
  output logic [NUM_CH-1:0]        chMask,
  output logic [NUM_CH*MODE_W-1:0] chMode,
  output logic [BYTE_W-1:0]        cmdReg,
  output logic [NUM_CH-1:0]        chReq
);
  dmaStrobes_t strb;

  dma_prog_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strb    (strb)
  );

  dma_prog_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .engWrEn     (engWrEn),
    .engWrCh     (engWrCh),
    .engWrAddr   (engWrAddr),
    .engWrCount  (engWrCount),
    .engTc       (engTc),
    .chBaseAddr  (chBaseAddr),
    .chBaseCount (chBaseCount),
    .chCurAddr   (chCurAddr),
    .chCurCount  (chCurCount),
    .chMask      (chMask),
    .chMode      (chMode),
    .cmdReg      (cmdReg),
    .chReq       (chReq)
  );
endmodule

// File: rtl/dma_prog_chk.sv
module dma_prog_chk
  import dma_prog_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [OFS_W-1:0]         busAddr,
  input logic [BYTE_W-1:0]        busWrData,
  input logic                     busWr,
  input logic                     engWrEn,
  input logic [NUM_CH*REG_W-1:0]  chBaseAddr,
  input logic [NUM_CH*REG_W-1:0]  chBaseCount,
  input logic [NUM_CH-1:0]        chMask,
  input logic [NUM_CH*MODE_W-1:0] chMode,
  input logic [BYTE_W-1:0]        cmdReg,
  input logic [NUM_CH-1:0]        chReq
);
  a_r10_master_clear: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == OFS_MCLR |=> chMask == '1 && cmdReg == '0 && chReq == '0);

  a_r7_mask_all: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == OFS_MASK_ALL |=> chMask == $past(busWrData[NUM_CH-1:0]));

  a_r8_clear_mask: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == OFS_CLR_MASK |=> chMask == '0);

  a_r6_single_mask: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == OFS_MASK1 |=>
      chMask[$past(busWrData[CH_W-1:0])] == $past(busWrData[CH_W]));

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == OFS_MODE) |=> $stable(chMode));

  a_r13_base_hold: assert property (@(posedge clk) disable iff (!rstN)
    engWrEn && !busWr |=> $stable(chBaseAddr) && $stable(chBaseCount));
endmodule

bind dma_prog_regs dma_prog_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrData   (busWrData),
  .busWr       (busWr),
  .engWrEn     (engWrEn),
  .chBaseAddr  (chBaseAddr),
  .chBaseCount (chBaseCount),
  .chMask      (chMask),
  .chMode      (chMode),
  .cmdReg      (cmdReg),
  .chReq       (chReq)
);

// File: tb/dma_prog_regs_tb.sv
module dma_prog_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  // {isRead, offset[3:0], data-or-expected[7:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 4'hC, 8'h00}, {1'b0, 4'h2, 8'h34}, {1'b0, 4'h2, 8'h12},
    {1'b1, 4'h2, 8'h34}, {1'b1, 4'h2, 8'h12}, {1'b0, 4'h3, 8'hFF},
    {1'b0, 4'h3, 8'h00}, {1'b1, 4'h3, 8'hFF}, {1'b1, 4'h3, 8'h00},
    {1'b0, 4'h0, 8'hAA}, {1'b0, 4'hC, 8'h00}, {1'b0, 4'h0, 8'h55},
    {1'b0, 4'h0, 8'h66}, {1'b1, 4'h0, 8'h55}, {1'b1, 4'h0, 8'h66},
    {1'b1, 4'h6, 8'h00}, {1'b1, 4'h6, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busRdData;
  logic engWrEn = 1'b0;
  logic [1:0] engWrCh = '0;
  logic [15:0] engWrAddr = '0, engWrCount = '0;
  logic [3:0] engTc = '0;
  logic [63:0] chBaseAddr, chBaseCount, chCurAddr, chCurCount;
  logic [3:0] chMask, chReq;
  logic [23:0] chMode;
  logic [7:0] cmdReg;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;

  dma_prog_regs u_dut (.*);

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic busOp(input bit rd, input logic [3:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = !rd; busRd = rd;
    #1;
    if (rd) check(tag, 64'(busRdData), 64'(d));
    @(posedge clk); #1;
    busWr = 1'b0; busRd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    busOp(1'b0, a, d, "wr");
  endtask

  task automatic engOp(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c, input logic [3:0] tc, input bit en);
    @(negedge clk);
    engWrEn = en; engWrCh = ch; engWrAddr = a; engWrCount = c; engTc = tc;
    @(posedge clk); #1;
    engWrEn = 1'b0; engTc = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 mask", 64'(chMask), 64'hF);
    check("R1 cmd", 64'(cmdReg), 64'h0);
    check("R1 base addr", chBaseAddr, 64'h0);
    check("R1 mode", 64'(chMode), 64'h0);

    // R2 R3 R4 R5 byte sequencing walked from the table
    for (int i = 0; i < NVEC; i++) begin
      busOp(VEC[i][12], VEC[i][11:8], VEC[i][7:0], $sformatf("R2/R3/R4/R5 vec %0d", i));
    end
    @(negedge clk);
    check("R2 ch1 base addr", 64'(chBaseAddr[31:16]), 64'h1234);
    check("R3 ch1 base count", 64'(chBaseCount[31:16]), 64'h00FF);
    check("R5 ch0 addr after clear", 64'(chBaseAddr[15:0]), 64'h6655);

    // R8 R6 R7
    wr(4'hE, 8'h00);
    @(negedge clk); check("R8 clear mask", 64'(chMask), 64'h0);
    wr(4'hA, 8'h06);
    @(negedge clk); check("R6 mask ch2", 64'(chMask), 64'h4);
    wr(4'hF, 8'h0A);
    @(negedge clk); check("R7 mask all", 64'(chMask), 64'hA);
    wr(4'hA, 8'h03);
    @(negedge clk); check("R6 unmask ch3", 64'(chMask), 64'h2);

    // R9 mode
    wr(4'hB, 8'h45);
    wr(4'hB, 8'hC3);
    wr(4'hB, 8'h5A);
    @(negedge clk);
    check("R9 mode ch1", 64'(chMode[11:6]), 64'h11);
    check("R9 mode ch3", 64'(chMode[23:18]), 64'h30);
    check("R9 mode ch2", 64'(chMode[17:12]), 64'h16);
    check("R9 mode ch0", 64'(chMode[5:0]), 64'h00);

    // R13 engine writeback
    engOp(2'd1, 16'h1300, 16'h00FE, 4'h0, 1'b1);
    wr(4'hC, 8'h00);
    busOp(1'b1, 4'h2, 8'h00, "R13 cur addr lo");
    busOp(1'b1, 4'h2, 8'h13, "R13 cur addr hi");
    busOp(1'b1, 4'h3, 8'hFE, "R13 cur count lo");
    busOp(1'b1, 4'h3, 8'h00, "R13 cur count hi");
    @(negedge clk);
    check("R13 base addr kept", 64'(chBaseAddr[31:16]), 64'h1234);
    check("R13 base count kept", 64'(chBaseCount[31:16]), 64'h00FF);

    // R11 R12 command, request, status
    wr(4'h8, 8'h5A);
    wr(4'h9, 8'h05);
    wr(4'h9, 8'h07);
    wr(4'h9, 8'h03);
    engOp(2'd0, 16'h0, 16'h0, 4'h2, 1'b0);
    @(negedge clk);
    check("R11 cmd", 64'(cmdReg), 64'h5A);
    check("R12 req", 64'(chReq), 64'h2);
    busOp(1'b1, 4'h8, 8'h22, "R11 status with tc");
    busOp(1'b1, 4'h8, 8'h20, "R11 status tc cleared");

    // R10 master clear with pointer left on the high byte
    busOp(1'b1, 4'h0, 8'h55, "R4 ch0 lo before mclr");
    wr(4'hD, 8'h00);
    @(negedge clk);
    check("R10 mask", 64'(chMask), 64'hF);
    check("R10 cmd", 64'(cmdReg), 64'h0);
    check("R10 req", 64'(chReq), 64'h0);
    check("R10 mode kept", 64'(chMode[11:6]), 64'h11);
    busOp(1'b1, 4'h0, 8'h55, "R10 pointer reset to low");
    busOp(1'b1, 4'h8, 8'h00, "R10 status cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule